// File: doc/BRIEF.md
# Single-Wire Bus Master Reset and Slot Sequencer

This block drives an open-drain single-wire bus as the master, one bit-level operation per command. A command is offered on a valid/ready handshake with a two-bit opcode and a write bit. The block then produces one of four waveforms: a reset followed by presence detection, a write-0 slot, a write-1 slot, or a read slot. A speed select picks either the standard or the overdrive timing set. That choice is captured when the command is accepted and governs the whole waveform.

The block controls the line only through a registered pull-down enable. It observes the line through a two-flop synchronizer. Every waveform starts with the master pulling the line low. The reset low time is stretched by an extra fall-time allowance, to cover a master whose falling edge is slew-rate limited. After the master releases the line, the block samples it once, at a fixed point inside the high window. A low level at that point is taken as a slave's presence answer. Each slot ends with a recovery time of released line. After that a one-cycle done strobe is raised and the next command can be accepted. Byte assembly and device-level commands belong to the layer above.

All durations are parameters counted in clock cycles. The defaults assume one cycle per microsecond.

Top module: `sw_slot_master`

## Requirements
- R1: Opcode 2'b00 starts a reset. At standard speed the pull-down is on for RST_LOW_STD+FALL_EXT cycles (default 484). At overdrive it is on for RST_LOW_OD+FALL_EXT cycles (default 74). done_o rises RST_HIGH_STD (480) or RST_HIGH_OD (48) cycles after the pull-down ends.
- R2: During a reset the line is sampled once, MSP_STD (70) or MSP_OD (8) cycles after release, through a two-flop synchronizer. presence_o becomes 1 if the line was low and 0 if it was high, and it holds that value until the next reset.
- R3: Opcode 2'b01 is a write. With wr_bit_i=0 the pull-down is on for W0_LOW_STD (60) or W0_LOW_OD (8) cycles. With wr_bit_i=1 it is on for W1_LOW_STD (6) or W1_LOW_OD (1) cycles. done_o rises SLOT+REC cycles after acceptance (75 at standard speed, 12 at overdrive).
- R4: Opcodes 2'b10 and 2'b11 are a read. The pull-down is on for the write-1 low time. The line is sampled RD_SAMP_STD (15) or RD_SAMP_OD (4) cycles into the slot, and rd_bit_o takes the sampled level and holds it until the next read. done_o rises after SLOT+REC cycles.
- R5: The speed select is captured at acceptance. Changing od_i while an operation is running has no effect on that operation.
- R6: cmd_ready_o is low from acceptance until done_o. Commands offered while it is low are ignored.
- R7: done_o is a one-cycle pulse, and cmd_ready_o returns high in the same cycle.
- R8: After reset: pd_o=0, cmd_ready_o=1, done_o=0, presence_o=0, rd_bit_o=1.
- R9: pd_o is a register output that goes high in the first cycle after acceptance.
- R10: A slave low pulse that ends before the presence sample point does not set presence_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command accepted on valid |
| op_i | input | 2 | 00 reset, 01 write, 1x read |
| wr_bit_i | input | 1 | Bit value for a write |
| od_i | input | 1 | 1 selects overdrive timing |
| line_i | input | 1 | Bus level as read back from the pad |
| pd_o | output | 1 | Pull-down enable for the open-drain driver |
| presence_o | output | 1 | Presence seen in the last reset |
| rd_bit_o | output | 1 | Bit captured by the last read |
| done_o | output | 1 | Operation finished, one cycle |

## Verification
The bench models the bus as the wired AND of the master pull-down and a slave pull-down whose window it controls. Resets are run with three slave behaviours: a long answer straddling the sample point, no answer, and a short answer that ends before the sample point. These separate correct single-point sampling from edge detection or sampling at the wrong time. Writes of both values and reads against a held-low and a released line are run at both speeds. These distinguish the low-time choice per opcode and per speed, and whether the sample comes before or after the master release. Toggling the speed mid-operation and offering commands while busy show whether the speed and the command are latched at acceptance.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;
  localparam int unsigned TW = 16;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } sw_op_e;

  typedef struct packed {
    logic [TW-1:0] rst_low;   // includes fall-time stretch
    logic [TW-1:0] rst_high;
    logic [TW-1:0] msp;
    logic [TW-1:0] w0_low;
    logic [TW-1:0] w1_low;
    logic [TW-1:0] rd_samp;
    logic [TW-1:0] slot;
    logic [TW-1:0] rec;
  } sw_tim_t;
endpackage

// File: rtl/sw_tim_sel.sv
module sw_tim_sel
  import sw_slot_pkg::*;
#(
  parameter int unsigned FALL_EXT    = 4,
  parameter int unsigned RST_LOW_STD = 480,
  parameter int unsigned RST_HI_STD  = 480,
  parameter int unsigned MSP_STD     = 70,
  parameter int unsigned W0_LOW_STD  = 60,
  parameter int unsigned W1_LOW_STD  = 6,
  parameter int unsigned RD_SAMP_STD = 15,
  parameter int unsigned SLOT_STD    = 70,
  parameter int unsigned REC_STD     = 5,
  parameter int unsigned RST_LOW_OD  = 70,
  parameter int unsigned RST_HI_OD   = 48,
  parameter int unsigned MSP_OD      = 8,
  parameter int unsigned W0_LOW_OD   = 8,
  parameter int unsigned W1_LOW_OD   = 1,
  parameter int unsigned RD_SAMP_OD  = 4,
  parameter int unsigned SLOT_OD     = 10,
  parameter int unsigned REC_OD      = 2
) (
  input  logic    od_i,
  output sw_tim_t tim_o
);
  localparam sw_tim_t TIM_STD = '{
    rst_low: TW'(RST_LOW_STD + FALL_EXT), rst_high: TW'(RST_HI_STD),
    msp: TW'(MSP_STD), w0_low: TW'(W0_LOW_STD), w1_low: TW'(W1_LOW_STD),
    rd_samp: TW'(RD_SAMP_STD), slot: TW'(SLOT_STD), rec: TW'(REC_STD)};
  localparam sw_tim_t TIM_OD = '{
    rst_low: TW'(RST_LOW_OD + FALL_EXT), rst_high: TW'(RST_HI_OD),
    msp: TW'(MSP_OD), w0_low: TW'(W0_LOW_OD), w1_low: TW'(W1_LOW_OD),
    rd_samp: TW'(RD_SAMP_OD), slot: TW'(SLOT_OD), rec: TW'(REC_OD)};

  assign tim_o = od_i ? TIM_OD : TIM_STD;
endmodule

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // idle bus is high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
  import sw_slot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [1:0] op_i,
  input  logic       wr_bit_i,
  input  sw_tim_t    tim_i,
  input  logic       line_s_i,
  output logic       cmd_ready_o,
  output logic       pd_o,
  output logic       presence_o,
  output logic       rd_bit_o,
  output logic       done_o
);
  logic          busy_q, pd_q, pres_q, rdb_q, done_q, bit_q;
  sw_op_e        op_q;
  sw_tim_t       tim_q;
  logic [TW-1:0] cnt_q, cnt_nxt, low_len, samp_pt, end_pt;
  logic          accept;

  assign accept  = cmd_valid_i && !busy_q;
  assign cnt_nxt = cnt_q + 1'b1;

  always_comb begin
    unique case (op_q)
      OP_RESET: begin
        low_len = tim_q.rst_low;
        samp_pt = tim_q.rst_low + tim_q.msp;
        end_pt  = tim_q.rst_low + tim_q.rst_high;
      end
      OP_WRITE: begin
        low_len = bit_q ? tim_q.w1_low : tim_q.w0_low;
        samp_pt = '1;
        end_pt  = tim_q.slot + tim_q.rec;
      end
      default: begin
        low_len = tim_q.w1_low;
        samp_pt = tim_q.rd_samp;
        end_pt  = tim_q.slot + tim_q.rec;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pd_q   <= 1'b0;
      pres_q <= 1'b0;
      rdb_q  <= 1'b1;
      done_q <= 1'b0;
      bit_q  <= 1'b0;
      op_q   <= OP_RESET;
      tim_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (accept) begin
          busy_q <= 1'b1;
          op_q   <= op_i[1] ? OP_READ : sw_op_e'(op_i);
          bit_q  <= wr_bit_i;
          tim_q  <= tim_i;
          cnt_q  <= '0;
          pd_q   <= 1'b1;  // every operation opens with a low
        end
      end else begin
        cnt_q <= cnt_nxt;
        pd_q  <= cnt_nxt < low_len;
        if (cnt_q == samp_pt) begin
          if (op_q == OP_RESET)     pres_q <= !line_s_i;
          else if (op_q == OP_READ) rdb_q  <= line_s_i;
        end
        if (cnt_nxt == end_pt) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pd_q   <= 1'b0;
        end
      end
    end
  end

  assign cmd_ready_o = !busy_q;
  assign pd_o        = pd_q;
  assign presence_o  = pres_q;
  assign rd_bit_o    = rdb_q;
  assign done_o      = done_q;

  // R6
  pd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> !cmd_ready_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);
  // R9
  accept_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> pd_o);
  // R2
  pres_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o || op_q != OP_RESET) |=> $stable(presence_o));
endmodule

// File: rtl/sw_slot_master.sv
module sw_slot_master
  import sw_slot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FALL_EXT    = 4,
  parameter int unsigned RST_LOW_STD = 480,
  parameter int unsigned RST_HI_STD  = 480,
  parameter int unsigned MSP_STD     = 70,
  parameter int unsigned W0_LOW_STD  = 60,
  parameter int unsigned W1_LOW_STD  = 6,
  parameter int unsigned RD_SAMP_STD = 15,
  parameter int unsigned SLOT_STD    = 70,
  parameter int unsigned REC_STD     = 5,
  parameter int unsigned RST_LOW_OD  = 70,
  parameter int unsigned RST_HI_OD   = 48,
  parameter int unsigned MSP_OD      = 8,
  parameter int unsigned W0_LOW_OD   = 8,
  parameter int unsigned W1_LOW_OD   = 1,
  parameter int unsigned RD_SAMP_OD  = 4,
  parameter int unsigned SLOT_OD     = 10,
  parameter int unsigned REC_OD      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  logic [1:0] op_i,
  input  logic       wr_bit_i,
  input  logic       od_i,
  input  logic       line_i,
  output logic       pd_o,
  output logic       presence_o,
  output logic       rd_bit_o,
  output logic       done_o
);
  sw_tim_t tim;
  logic    line_s;

  sw_tim_sel #(
    .FALL_EXT(FALL_EXT), .RST_LOW_STD(RST_LOW_STD), .RST_HI_STD(RST_HI_STD),
    .MSP_STD(MSP_STD), .W0_LOW_STD(W0_LOW_STD), .W1_LOW_STD(W1_LOW_STD),
    .RD_SAMP_STD(RD_SAMP_STD), .SLOT_STD(SLOT_STD), .REC_STD(REC_STD),
    .RST_LOW_OD(RST_LOW_OD), .RST_HI_OD(RST_HI_OD), .MSP_OD(MSP_OD),
    .W0_LOW_OD(W0_LOW_OD), .W1_LOW_OD(W1_LOW_OD), .RD_SAMP_OD(RD_SAMP_OD),
    .SLOT_OD(SLOT_OD), .REC_OD(REC_OD)
  ) u_tim (
    .od_i (od_i),
    .tim_o(tim)
  );

  sw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  sw_slot_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .op_i       (op_i),
    .wr_bit_i   (wr_bit_i),
    .tim_i      (tim),
    .line_s_i   (line_s),
    .cmd_ready_o(cmd_ready_o),
    .pd_o       (pd_o),
    .presence_o (presence_o),
    .rd_bit_o   (rd_bit_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/sim_sw_slot_master.sv
module sim_sw_slot_master;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0, wr_bit = 1'b0, od = 1'b0, slave_pd = 1'b0;
  logic [1:0] op = 2'b00;
  logic       cmd_ready, pd, presence, rd_bit, done, line;
  int         n_chk = 0, n_err = 0;

  assign line = !(pd || slave_pd);

  always #(CLK_PERIOD/2) clk = !clk;

  sw_slot_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .op_i(op), .wr_bit_i(wr_bit), .od_i(od), .line_i(line), .pd_o(pd),
    .presence_o(presence), .rd_bit_o(rd_bit), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one operation; slave pulls low for slot index in [s_from, s_to).
  // flip_od toggles speed mid-run, junk keeps offering a reset while busy.
  task automatic run_op(input logic [1:0] o, input logic b, input logic spd,
                        input int s_from, input int s_to, input bit flip_od,
                        input bit junk, output int low_cnt, output int total);
    low_cnt = 0;
    total   = -1;
    @(negedge clk);
    op = o; wr_bit = b; od = spd; cmd_valid = 1'b1;
    @(posedge clk);
    for (int idx = 0; idx < 5000; idx++) begin
      @(negedge clk);
      if (!junk) cmd_valid = 1'b0;
      else op = 2'b00;
      if (flip_od && idx == 2) od = !spd;
      slave_pd = (idx >= s_from) && (idx < s_to);
      if (pd) low_cnt++;
      if (done) begin
        chk("R7 ready with done", int'(cmd_ready), 1);
        total = idx;
        cmd_valid = 1'b0;
        slave_pd = 1'b0;
        break;
      end
    end
    if (total < 0) chk("R7 done never seen", 0, 1);
  endtask

  task automatic t_reset_state();
    chk("R8 pd", int'(pd), 0);
    chk("R8 ready", int'(cmd_ready), 1);
    chk("R8 done", int'(done), 0);
    chk("R8 presence", int'(presence), 0);
    chk("R8 rd_bit", int'(rd_bit), 1);
  endtask

  task automatic t_reset_std();
    int lo, tot;
    run_op(2'b00, 1'b0, 1'b0, 494, 584, 1'b0, 1'b0, lo, tot);
    chk("R1 std low", lo, 484);
    chk("R1 std total", tot, 964);
    chk("R2 presence seen", int'(presence), 1);
    run_op(2'b00, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R2 no presence", int'(presence), 0);
    run_op(2'b00, 1'b0, 1'b0, 489, 524, 1'b0, 1'b0, lo, tot);
    chk("R10 early pulse ignored", int'(presence), 0);
  endtask

  task automatic t_reset_od();
    int lo, tot;
    run_op(2'b00, 1'b0, 1'b1, 76, 94, 1'b0, 1'b0, lo, tot);
    chk("R1 od low", lo, 74);
    chk("R1 od total", tot, 122);
    chk("R2 od presence", int'(presence), 1);
  endtask

  task automatic t_write();
    int lo, tot;
    run_op(2'b01, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R3 w0 std low", lo, 60);
    chk("R3 w0 std total", tot, 75);
    chk("R2 presence held over write", int'(presence), 1);
    run_op(2'b01, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R3 w1 std low", lo, 6);
    chk("R3 w1 std total", tot, 75);
    run_op(2'b01, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R3 w0 od low", lo, 8);
    chk("R3 w0 od total", tot, 12);
    run_op(2'b01, 1'b1, 1'b1, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R3 w1 od low", lo, 1);
  endtask

  task automatic t_read();
    int lo, tot;
    run_op(2'b10, 1'b0, 1'b0, 0, 70, 1'b0, 1'b0, lo, tot);
    chk("R4 std read low", lo, 6);
    chk("R4 std read total", tot, 75);
    chk("R4 std read 0", int'(rd_bit), 0);
    run_op(2'b11, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R4 std read 1", int'(rd_bit), 1);
    run_op(2'b10, 1'b0, 1'b1, 0, 10, 1'b0, 1'b0, lo, tot);
    chk("R4 od read 0", int'(rd_bit), 0);
    chk("R4 od read total", tot, 12);
    run_op(2'b10, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0, lo, tot);
    chk("R4 od read 1", int'(rd_bit), 1);
  endtask

  task automatic t_speed_latch();
    int lo, tot;
    run_op(2'b01, 1'b0, 1'b0, 0, 0, 1'b1, 1'b0, lo, tot);
    chk("R5 std kept low", lo, 60);
    chk("R5 std kept total", tot, 75);
    run_op(2'b01, 1'b0, 1'b1, 0, 0, 1'b1, 1'b0, lo, tot);
    chk("R5 od kept low", lo, 8);
  endtask

  task automatic t_busy_ignore();
    int lo, tot, seen;
    run_op(2'b01, 1'b1, 1'b0, 0, 0, 1'b0, 1'b1, lo, tot);
    chk("R6 busy write low", lo, 6);
    chk("R6 busy write total", tot, 75);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (pd || !cmd_ready) seen++;
    end
    chk("R6 no queued command", seen, 0);
    @(negedge clk);
    op = 2'b01; wr_bit = 1'b0; od = 1'b0; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R9 pd one cycle after accept", int'(pd), 1);
    chk("R6 ready low while busy", int'(cmd_ready), 0);
    cmd_valid = 1'b0;
    wait (done);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_reset_std();
    t_reset_od();
    t_write();
    t_read();
    t_speed_latch();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule